// File: doc/BRIEF.md
# Miss-Tolerant Stall Slack Controller

This block decides, cycle by cycle, whether an in-order pipeline has to freeze while a data-cache miss is outstanding. Before a program runs, a loader fills an annotation table. Each annotation describes one hot basic block. It gives the PC of the first load of that block, the number of following instructions that are known not to depend on any load, and a packed list of extra slack that becomes available as each load of the block completes.

When a load sits in the memory stage and its PC matches a valid annotation, the block reloads a slack counter and an increment register from that entry. The counter drops by one on every cycle in which it is nonzero. Each completed load adds the next increment slot to it. The pipeline runs on through a pending miss for as long as slack remains, and stalls only once the counter reaches zero. With no annotation in play the counter sits at zero, so the pipeline stalls on every miss as a plain stall-on-miss pipeline would.

Top module: `slack_stall_ctrl`

## Requirements
- R1: After reset every table entry is invalid, slack reads 0, no lookup hits, and stall equals miss_pending.
- R2: A table write (tbl_we, tbl_idx, tbl_entry) is seen by lookups from the next cycle on. A hit needs ld_valid high, a valid entry, and ld_pc equal to entry bits [63:32]. A lookup in the same cycle as a write sees the table's old contents.
- R3: When several valid entries match, the entry with the lowest index supplies the count and the increments.
- R4: In the cycle after a hit, slack equals the 5-bit count held in entry bits [31:27].
- R5: With no hit and no load completion, a nonzero slack drops by exactly one per cycle, and a zero slack stays at zero.
- R6: Entry bits [26:0] hold nine 3-bit slots, with the first slot in [26:24] and the last in [2:0]. Each load_done without a hit adds the next unused slot to the slack after that cycle's decrement, and the slot order is followed. Once all nine slots are used, a load_done adds 0.
- R7: When a hit and load_done fall in the same cycle, the reload wins and the completed load's slot is discarded.
- R8: stall is high exactly when miss_pending is high and slack is 0. Without a miss, stall is never raised.
- R9: Slack never exceeds 94, the sum of the largest count and nine largest slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_idx | input | 8 | Table entry index to write |
| tbl_entry | input | 64 | Entry: PC [63:32], count [31:27], slots [26:0] |
| ld_valid | input | 1 | A load occupies the memory stage |
| ld_pc | input | 32 | PC of that load |
| miss_pending | input | 1 | The data cache has an unresolved miss |
| load_done | input | 1 | A load completes this cycle |
| stall | output | 1 | Freeze the pipeline |
| slack | output | 7 | Remaining guaranteed-independent instructions |
| blk_hit | output | 1 | The current load matched a valid annotation |

## Verification
The embedded properties check on every cycle the local update rules: the reload value after a hit, a drop of exactly one on quiet cycles, the 94 ceiling, the rule that reload wins over a completion, the lowest-index choice among matches, and the absence of stalls without a miss. Some behaviour is visible only from the bench's scenarios. This covers the order in which the nine slots are consumed, the zero added after the slots are used up, write-then-lookup visibility, and the full run from a miss through exhausted slack to a stall. The bench checks these against a model of the table and counter that it keeps itself.

// File: rtl/slack_pkg.sv
package slack_pkg;
  localparam int PC_W     = 32;
  localparam int CNT_W    = 5;
  localparam int SLOT_W   = 3;
  localparam int NSLOT    = 9;
  localparam int INCR_W   = SLOT_W * NSLOT;
  localparam int ENTRY_W  = PC_W + CNT_W + INCR_W;
  localparam int SLACK_W  = 7;
  localparam int MAX_SLACK = (2**CNT_W - 1) + NSLOT * (2**SLOT_W - 1);

  function automatic logic [PC_W-1:0] entry_pc(input logic [ENTRY_W-1:0] e);
    return e[ENTRY_W-1 -: PC_W];
  endfunction

  function automatic logic [CNT_W-1:0] entry_cnt(input logic [ENTRY_W-1:0] e);
    return e[INCR_W +: CNT_W];
  endfunction

  function automatic logic [INCR_W-1:0] entry_incr(input logic [ENTRY_W-1:0] e);
    return e[INCR_W-1:0];
  endfunction

  // one cycle of slack: spend one if any is left, then credit a slot
  function automatic logic [SLACK_W-1:0] next_slack(input logic [SLACK_W-1:0] cur,
                                                    input logic done,
                                                    input logic [SLOT_W-1:0] top);
    logic [SLACK_W-1:0] dec;
    dec = (cur != '0) ? cur - SLACK_W'(1) : cur;
    return dec + (done ? SLACK_W'(top) : SLACK_W'(0));
  endfunction
endpackage

// File: rtl/slack_table.sv
module slack_table
  import slack_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic [IDX_W-1:0]   widx,
  input  logic [ENTRY_W-1:0] wdata,
  input  logic               lk_valid,
  input  logic [PC_W-1:0]    lk_pc,
  output logic               hit,
  output logic [CNT_W-1:0]   hit_cnt,
  output logic [INCR_W-1:0]  hit_incr
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]   vld;
  logic [DEPTH-1:0]   hv;
  logic [IDX_W-1:0]   sel;

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else if (we) vld[widx] <= 1'b1;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign hv[g] = vld[g] && lk_valid && (entry_pc(mem[g]) == lk_pc);
  end

  always_comb begin
    sel = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (hv[i]) sel = IDX_W'(i);
    end
  end

  assign hit      = |hv;
  assign hit_cnt  = entry_cnt(mem[sel]);
  assign hit_incr = entry_incr(mem[sel]);

  // R3
  lowest_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (hv[sel] && ((hv & ((DEPTH'(1) << sel) - DEPTH'(1))) == '0)));
endmodule

// File: rtl/slack_counter.sv
module slack_counter
  import slack_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reload,
  input  logic [CNT_W-1:0]   rl_cnt,
  input  logic [INCR_W-1:0]  rl_incr,
  input  logic               done,
  output logic [SLACK_W-1:0] slack
);
  logic [INCR_W-1:0] incr_q;
  logic [SLOT_W-1:0] head_slot;

  assign head_slot = incr_q[INCR_W-1 -: SLOT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slack  <= '0;
      incr_q <= '0;
    end else if (reload) begin
      slack  <= SLACK_W'(rl_cnt);
      incr_q <= rl_incr;
    end else begin
      slack <= next_slack(slack, done, head_slot);
      if (done) incr_q <= incr_q << SLOT_W;
    end
  end

  // R4
  reload_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> slack == SLACK_W'($past(rl_cnt)));
  // R5
  quiet_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !done && slack != '0) |=> slack == $past(slack) - SLACK_W'(1));
  // R5
  quiet_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && !done && slack == '0) |=> slack == '0);
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slack <= SLACK_W'(MAX_SLACK));
endmodule

// File: rtl/slack_stall_ctrl.sv
module slack_stall_ctrl
  import slack_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_we,
  input  logic [IDX_W-1:0]   tbl_idx,
  input  logic [ENTRY_W-1:0] tbl_entry,
  input  logic               ld_valid,
  input  logic [PC_W-1:0]    ld_pc,
  input  logic               miss_pending,
  input  logic               load_done,
  output logic               stall,
  output logic [SLACK_W-1:0] slack,
  output logic               blk_hit
);
  logic [CNT_W-1:0]  hit_cnt;
  logic [INCR_W-1:0] hit_incr;

  slack_table #(.DEPTH(DEPTH)) tbl_i (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .widx(tbl_idx), .wdata(tbl_entry),
    .lk_valid(ld_valid), .lk_pc(ld_pc),
    .hit(blk_hit), .hit_cnt(hit_cnt), .hit_incr(hit_incr)
  );

  slack_counter cnt_i (
    .clk(clk), .rst_n(rst_n), .reload(blk_hit), .rl_cnt(hit_cnt),
    .rl_incr(hit_incr), .done(load_done), .slack(slack)
  );

  assign stall = miss_pending && (slack == '0);

  // R7
  reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_hit && load_done) |=> slack == SLACK_W'($past(hit_cnt)));
  // R8
  no_miss_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_pending |-> !stall);
endmodule

// File: tb/slack_stall_ctrl_tb_top.sv
module slack_stall_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tbl_we;
  logic [7:0]  tbl_idx;
  logic [63:0] tbl_entry;
  logic        ld_valid;
  logic [31:0] ld_pc;
  logic        miss_pending;
  logic        load_done;
  logic        stall;
  logic [6:0]  slack;
  logic        blk_hit;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  bit          m_vld [256];
  logic [63:0] m_ent [256];
  int          m_slack;
  logic [26:0] m_incr;
  int          m_k;
  bit          prev_hit, prev_done;

  always #4 clk = ~clk;

  slack_stall_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_entry(tbl_entry),
    .ld_valid(ld_valid), .ld_pc(ld_pc), .miss_pending(miss_pending), .load_done(load_done),
    .stall(stall), .slack(slack), .blk_hit(blk_hit)
  );

  function automatic logic [63:0] mk_entry(input logic [31:0] pc, input int cnt,
                                           input int s0, input int s1, input int s2,
                                           input int s3, input int s4, input int s5,
                                           input int s6, input int s7, input int s8);
    logic [26:0] inc;
    inc = {s0[2:0], s1[2:0], s2[2:0], s3[2:0], s4[2:0], s5[2:0], s6[2:0], s7[2:0], s8[2:0]};
    return {pc, cnt[4:0], inc};
  endfunction

  function automatic int exp_sel(input logic lv, input logic [31:0] pc);
    if (!lv) return -1;
    for (int i = 0; i < 256; i++)
      if (m_vld[i] && m_ent[i][63:32] == pc) return i;
    return -1;
  endfunction

  function automatic int slot_val(input logic [26:0] inc, input int k);
    if (k >= 9) return 0;
    return int'((inc >> (3 * (8 - k))) & 27'd7);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] idx, input logic [63:0] ent,
                      input logic lv, input logic [31:0] pc, input logic miss,
                      input logic done, input string rtag);
    int sel;
    string stag;
    tbl_we = we; tbl_idx = idx; tbl_entry = ent;
    ld_valid = lv; ld_pc = pc; miss_pending = miss; load_done = done;
    #2;
    sel = exp_sel(lv, pc);
    if (rtag != "") stag = rtag;
    else if (prev_hit && prev_done) stag = "R7";
    else if (prev_hit) stag = "R4";
    else if (prev_done) stag = "R6";
    else stag = "R5";
    chk(int'(slack) == m_slack, stag, int'(slack), m_slack);
    chk(slack <= 7'd94, "R9", int'(slack), 94);
    chk(stall == (miss && m_slack == 0), (rtag != "") ? rtag : "R8", int'(stall),
        int'(miss && m_slack == 0));
    chk(blk_hit == (sel >= 0), (rtag != "") ? rtag : "R2", int'(blk_hit), int'(sel >= 0));
    @(posedge clk);
    prev_hit = (sel >= 0);
    prev_done = done;
    if (sel >= 0) begin
      m_slack = int'(m_ent[sel][31:27]);
      m_incr = m_ent[sel][26:0];
      m_k = 0;
    end else begin
      m_slack = (m_slack > 0) ? m_slack - 1 : 0;
      if (done) begin
        m_slack += slot_val(m_incr, m_k);
        if (m_k < 9) m_k++;
      end
    end
    if (we) begin
      m_vld[idx] = 1'b1;
      m_ent[idx] = ent;
    end
    @(negedge clk);
  endtask

  task automatic idle(input logic miss, input logic done, input int n);
    for (int i = 0; i < n; i++) step(0, 8'd0, 64'd0, 0, 32'd0, miss, done, "");
  endtask

  initial begin
    logic [31:0] pool [8];
    int seed_dummy;
    rst_n = 1'b0;
    tbl_we = 0; tbl_idx = 0; tbl_entry = 0; ld_valid = 0; ld_pc = 0;
    miss_pending = 0; load_done = 0;
    for (int i = 0; i < 256; i++) begin m_vld[i] = 0; m_ent[i] = '0; end
    m_slack = 0; m_incr = '0; m_k = 0; prev_hit = 0; prev_done = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, miss stalls at once, nothing hits
    step(0, 8'd0, 64'd0, 1, 32'd0, 1, 0, "R1");
    step(0, 8'd0, 64'd0, 1, 32'h1000, 0, 0, "R1");

    // R2: write then look up next cycle; same-cycle lookup sees old table
    step(1, 8'd5, mk_entry(32'h1000, 4, 1, 2, 3, 4, 5, 6, 7, 0, 3), 1, 32'h1000, 1, 0, "");
    // R3: duplicate PC at higher index must lose
    step(1, 8'd9, mk_entry(32'h1000, 20, 7, 7, 7, 7, 7, 7, 7, 7, 7), 0, 32'h0, 1, 0, "");
    step(1, 8'd200, mk_entry(32'h2000, 31, 7, 7, 7, 7, 7, 7, 7, 7, 7), 0, 32'h0, 1, 0, "");
    step(0, 8'd0, 64'd0, 1, 32'h1000, 0, 0, "R3");
    // R4/R5: count 4 runs down under a miss, then R8 stall
    idle(1, 0, 6);
    // R6: slots consumed in order 1,2,3,...
    step(0, 8'd0, 64'd0, 1, 32'h1000, 1, 0, "");
    for (int i = 0; i < 11; i++) step(0, 8'd0, 64'd0, 0, 32'd0, 1, 1, "");
    idle(1, 0, 40);
    // R2: ld_valid low ignores a matching PC
    step(0, 8'd0, 64'd0, 0, 32'h2000, 1, 0, "R2");
    // R7: reload and completion together
    step(0, 8'd0, 64'd0, 1, 32'h1000, 1, 0, "");
    step(0, 8'd0, 64'd0, 0, 32'd0, 1, 1, "");
    step(0, 8'd0, 64'd0, 1, 32'h2000, 1, 1, "");
    // R9: largest entry with back-to-back completions
    for (int i = 0; i < 10; i++) step(0, 8'd0, 64'd0, 0, 32'd0, 0, 1, "");
    idle(0, 0, 5);

    // random mix with fixed seed
    seed_dummy = $urandom(32'h5EED);
    for (int i = 0; i < 8; i++) pool[i] = 32'h4000 + 32'($urandom_range(0, 15)) * 4;
    for (int c = 0; c < 3000; c++) begin
      logic we, lv, ms, dn;
      logic [7:0] ix;
      logic [63:0] en;
      we = ($urandom_range(0, 99) < 5);
      ix = 8'($urandom_range(0, 15)) + ((c % 3 == 0) ? 8'd240 : 8'd0);
      en = {pool[$urandom_range(0, 7)], 32'($urandom)};
      lv = ($urandom_range(0, 99) < 25);
      ms = ($urandom_range(0, 99) < 60);
      dn = ($urandom_range(0, 99) < 25);
      step(we, ix, en, lv, pool[$urandom_range(0, 7)], ms, dn, "");
    end
    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule